// File: doc/BRIEF.md
# Multi-Chain Mux-D Scan Wrapper

This block wraps a small sequential circuit so that every state flip-flop can be loaded and unloaded serially for test. Each state bit sits in a scan cell whose D input passes through a two-way selector. With the shared test-control input low, every cell loads the next-state value from the combinational core. With it high, the cells form shift registers. The core reads the cell outputs as extra inputs, and the values it presents at the cell inputs act as extra outputs that a capture records.

The cells are split across several independent chains. Each chain has its own serial input and output, and one test-control pin drives all of them. Every chain is given the same length, the ceiling of cells over chains. The last chain takes any shortfall as pad cells at its serial-input end, so all chains finish a load on the same clock. A tester shifts a starting state in, drops test control for one capture clock with the primary inputs applied, and reads the primary outputs. It then raises test control again. The captured response streams out while the next starting state streams in. The wrapped example core is a rotate-and-xor next-state function with an xor output function.

Top module: `mux_scan_wrapper`

## Requirements
- R1: A high rst at a clock edge clears every cell to 0, pads included, whatever testCtl and scanIn are. scanOut is all zero after that edge.
- R2: While testCtl is high, each chain moves one position per clock toward its output. A bit presented on scanIn[c] appears on scanOut[c] exactly L = ceil(NUM_CELLS/NUM_CHAINS) clocks later, for every chain.
- R3: A clock with testCtl low and rst low loads state bit i with state[(i-1) mod NUM_CELLS] xor pi[i mod PI_W].
- R4: po[j] equals state[j mod NUM_CELLS] xor pi[j mod PI_W], combinationally.
- R5: Position 0 of a chain is its scanIn end and position L-1 drives its scanOut. For chain c below the last chain, state bit c*L+k sits at position k. The last chain holds pads at positions 0 to P-1, where P = NUM_CHAINS*L - NUM_CELLS. Its state bits (NUM_CHAINS-1)*L + k - P sit at positions k >= P.
- R6: A bit shifted into one chain never reaches the scanOut of another chain.
- R7: In the L shift clocks that follow a capture, scanOut[c] presents the captured contents of chain c, position L-1 first. In the same clocks the next starting state enters, so that after those L clocks the chain holds the new state.
- R8: A capture clock clears every pad cell to 0, so the last P bits unloaded from the last chain after a capture are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all scan cells |
| rst | input | 1 | Synchronous reset, active high, wins over testCtl |
| testCtl | input | 1 | 1 = shift along chains, 0 = capture from the core |
| pi | input | PI_W | Primary inputs to the core |
| scanIn | input | NUM_CHAINS | Serial input, one per chain |
| po | output | PO_W | Primary outputs of the core |
| scanOut | output | NUM_CHAINS | Serial output, last cell of each chain |

## Verification
Unloading the response of one pattern and loading the start state of the next occur in the same shift clocks. The bench drives a fresh vector into every chain while it compares each scanOut bit with the model's captured value at the matching position, over several capture and input patterns. Reset and shift can also collide. The bench holds testCtl high with all scanIn bits at 1 through reset, and again after a stream of shifting. It then unloads to confirm that reset won and that the pads hold 0.

// File: rtl/mux_scan_pkg.sv
package mux_scan_pkg;

  // Per-clock action chosen by the control for every cell
  typedef struct packed {
    logic clear;
    logic shift;
    logic capture;
  } scan_strobe_t;

endpackage

// File: rtl/scan_mode_ctrl.sv
module scan_mode_ctrl
  import mux_scan_pkg::*;
(
  input  logic         rst,
  input  logic         testCtl,
  output scan_strobe_t strobe
);

  // Reset has priority over both shift and capture
  always_comb begin
    strobe = '0;
    if (rst)          strobe.clear   = 1'b1;
    else if (testCtl) strobe.shift   = 1'b1;
    else              strobe.capture = 1'b1;
  end

endmodule

// File: rtl/scan_demo_core.sv
module scan_demo_core #(
  parameter int NUM_CELLS = 10,
  parameter int PI_W      = 4,
  parameter int PO_W      = 4
) (
  input  logic [NUM_CELLS-1:0] stateQ,
  input  logic [PI_W-1:0]      pi,
  output logic [NUM_CELLS-1:0] nextState,
  output logic [PO_W-1:0]      po
);

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_next
    assign nextState[i] = stateQ[(i + NUM_CELLS - 1) % NUM_CELLS] ^ pi[i % PI_W];
  end

  for (genvar j = 0; j < PO_W; j++) begin : g_out
    assign po[j] = stateQ[j % NUM_CELLS] ^ pi[j % PI_W];
  end

endmodule

// File: rtl/scan_cell_array.sv
module scan_cell_array
  import mux_scan_pkg::*;
#(
  parameter int NUM_CELLS  = 10,
  parameter int NUM_CHAINS = 3
) (
  input  logic                                   clk,
  input  scan_strobe_t                           strobe,
  input  logic [NUM_CHAINS-1:0]                  scanIn,
  input  logic [NUM_CELLS-1:0]                   coreNext,
  output logic [NUM_CELLS-1:0]                   stateQ,
  output logic [NUM_CHAINS*((NUM_CELLS+NUM_CHAINS-1)/NUM_CHAINS)-1:0] slotQ,
  output logic [NUM_CHAINS-1:0]                  scanOut
);

  localparam int CHAIN_LEN = (NUM_CELLS + NUM_CHAINS - 1) / NUM_CHAINS;
  localparam int NUM_SLOTS = CHAIN_LEN * NUM_CHAINS;
  localparam int PAD_CNT   = NUM_SLOTS - NUM_CELLS;
  localparam int PAD_BASE  = (NUM_CHAINS - 1) * CHAIN_LEN;

  logic [NUM_SLOTS-1:0] slotReg;

  // Slot index = chain * CHAIN_LEN + position; position 0 is the scan-in end
  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
    for (genvar k = 0; k < CHAIN_LEN; k++) begin : g_cell
      localparam int  SLOT   = c * CHAIN_LEN + k;
      localparam bit  IS_PAD = (c == NUM_CHAINS - 1) && (k < PAD_CNT);
      localparam int  CELL   = (SLOT < PAD_BASE) ? SLOT : SLOT - PAD_CNT;

      logic shiftSrc;
      logic captureSrc;
      logic cellQ;

      if (k == 0) begin : g_head
        assign shiftSrc = scanIn[c];
      end else begin : g_body
        assign shiftSrc = slotReg[SLOT-1];
      end

      if (IS_PAD) begin : g_pad
        assign captureSrc = 1'b0;
      end else begin : g_real
        assign captureSrc = coreNext[CELL];
      end

      always_ff @(posedge clk) begin
        if (strobe.clear)        cellQ <= 1'b0;
        else if (strobe.shift)   cellQ <= shiftSrc;
        else if (strobe.capture) cellQ <= captureSrc;
      end

      assign slotReg[SLOT] = cellQ;
    end

    assign scanOut[c] = slotReg[c*CHAIN_LEN + CHAIN_LEN - 1];
  end

  // Gather the real cells into the core's state vector, skipping pads
  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_state
    localparam int SRC = (i < PAD_BASE) ? i : i + PAD_CNT;
    assign stateQ[i] = slotReg[SRC];
  end

  assign slotQ = slotReg;

endmodule

// File: rtl/mux_scan_wrapper.sv
module mux_scan_wrapper
  import mux_scan_pkg::*;
#(
  parameter int NUM_CELLS  = 10,
  parameter int NUM_CHAINS = 3,
  parameter int PI_W       = 4,
  parameter int PO_W       = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  testCtl,
  input  logic [PI_W-1:0]       pi,
  input  logic [NUM_CHAINS-1:0] scanIn,
  output logic [PO_W-1:0]       po,
  output logic [NUM_CHAINS-1:0] scanOut
);

  localparam int CHAIN_LEN = (NUM_CELLS + NUM_CHAINS - 1) / NUM_CHAINS;
  localparam int NUM_SLOTS = CHAIN_LEN * NUM_CHAINS;

  scan_strobe_t         strobe;
  logic [NUM_CELLS-1:0] stateQ;
  logic [NUM_CELLS-1:0] coreNext;
  logic [NUM_SLOTS-1:0] slotQ;

  scan_mode_ctrl u_ctrl (
    .rst     (rst),
    .testCtl (testCtl),
    .strobe  (strobe)
  );

  scan_cell_array #(
    .NUM_CELLS  (NUM_CELLS),
    .NUM_CHAINS (NUM_CHAINS)
  ) u_cells (
    .clk      (clk),
    .strobe   (strobe),
    .scanIn   (scanIn),
    .coreNext (coreNext),
    .stateQ   (stateQ),
    .slotQ    (slotQ),
    .scanOut  (scanOut)
  );

  scan_demo_core #(
    .NUM_CELLS (NUM_CELLS),
    .PI_W      (PI_W),
    .PO_W      (PO_W)
  ) u_core (
    .stateQ    (stateQ),
    .pi        (pi),
    .nextState (coreNext),
    .po        (po)
  );

endmodule

// File: rtl/mux_scan_wrapper_chk.sv
module mux_scan_wrapper_chk #(
  parameter int NUM_CELLS  = 10,
  parameter int NUM_CHAINS = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  testCtl,
  input logic [NUM_CHAINS-1:0] scanIn,
  input logic [NUM_CHAINS-1:0] scanOut,
  input logic [NUM_CHAINS*((NUM_CELLS+NUM_CHAINS-1)/NUM_CHAINS)-1:0] slotQ,
  input logic [NUM_CELLS-1:0]  stateQ,
  input logic [NUM_CELLS-1:0]  coreNext
);

  localparam int CHAIN_LEN = (NUM_CELLS + NUM_CHAINS - 1) / NUM_CHAINS;
  localparam int NUM_SLOTS = CHAIN_LEN * NUM_CHAINS;
  localparam int PAD_CNT   = NUM_SLOTS - NUM_CELLS;
  localparam int PAD_BASE  = (NUM_CHAINS - 1) * CHAIN_LEN;

  // R1: the clock after reset leaves every cell at zero
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (slotQ == '0 && scanOut == '0));

  // R2: scanOut takes what sat one position before the end on the prior shift clock
  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_shift
    if (CHAIN_LEN > 1) begin : g_long
      p_chain_shift_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(testCtl) && !$past(rst)) |-> scanOut[c] == $past(slotQ[c*CHAIN_LEN + CHAIN_LEN - 2]));
    end else begin : g_single
      p_chain_shift_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(testCtl) && !$past(rst)) |-> scanOut[c] == $past(scanIn[c]));
    end
  end

  // R3: a capture clock records the core's next-state outputs
  p_capture_core_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(testCtl) && !$past(rst)) |-> stateQ == $past(coreNext));

  // R8: pad cells are zero after a capture
  if (PAD_CNT > 0) begin : g_pad
    p_pad_capture_r8: assert property (@(posedge clk) disable iff (rst)
      (!$past(testCtl) && !$past(rst)) |-> slotQ[PAD_BASE +: PAD_CNT] == '0);
  end

endmodule

bind mux_scan_wrapper mux_scan_wrapper_chk #(
  .NUM_CELLS  (NUM_CELLS),
  .NUM_CHAINS (NUM_CHAINS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .testCtl  (testCtl),
  .scanIn   (scanIn),
  .scanOut  (scanOut),
  .slotQ    (slotQ),
  .stateQ   (stateQ),
  .coreNext (coreNext)
);

// File: tb/mux_scan_wrapper_tb.sv
`timescale 1ns/1ps
module mux_scan_wrapper_tb;

  localparam int N   = 10;
  localparam int NC  = 3;
  localparam int PIW = 4;
  localparam int POW = 4;
  localparam int L   = (N + NC - 1) / NC;
  localparam int P   = NC * L - N;
  localparam int PB  = (NC - 1) * L;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           testCtl = 1'b1;
  logic [PIW-1:0] pi = '0;
  logic [NC-1:0]  scanIn = '0;
  logic [POW-1:0] po;
  logic [NC-1:0]  scanOut;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [N-1:0] model = '0;
  logic         padModel = 1'b0;

  always #2 clk = ~clk;

  mux_scan_wrapper #(
    .NUM_CELLS(N), .NUM_CHAINS(NC), .PI_W(PIW), .PO_W(POW)
  ) u_dut (
    .clk(clk), .rst(rst), .testCtl(testCtl), .pi(pi),
    .scanIn(scanIn), .po(po), .scanOut(scanOut)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // R5 placement of state bits and pads
  function automatic logic slotBit(input logic [N-1:0] st, input logic padV, input int c, input int k);
    if (c < NC - 1) return st[c*L + k];
    if (k < P) return padV;
    return st[PB + k - P];
  endfunction

  function automatic logic [N-1:0] nextOf(input logic [N-1:0] st, input logic [PIW-1:0] p);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = st[(i + N - 1) % N] ^ p[i % PIW];
    return r;
  endfunction

  function automatic logic [POW-1:0] poOf(input logic [N-1:0] st, input logic [PIW-1:0] p);
    logic [POW-1:0] r;
    for (int j = 0; j < POW; j++) r[j] = st[j % N] ^ p[j % PIW];
    return r;
  endfunction

  function automatic logic streamBit(input int t, input int c);
    return ((t * 5 + c * 3) % 7) < 3;
  endfunction

  // Unload the model's contents while loading loadVec (pads loaded with 1)
  task automatic shiftPattern(input logic [N-1:0] loadVec, input string req);
    testCtl = 1'b1;
    for (int t = 0; t < L; t++) begin
      for (int c = 0; c < NC; c++) begin
        int pos = L - 1 - t;
        string tag = (c == NC - 1 && pos < P) ? "R8" : req;
        check(tag, $sformatf("unload chain%0d pos%0d", c, pos), 32'(scanOut[c]), 32'(slotBit(model, padModel, c, pos)));
        scanIn[c] = slotBit(loadVec, 1'b1, c, pos);
      end
      step();
    end
    model = loadVec;
    padModel = 1'b1;
  endtask

  task automatic capture(input logic [PIW-1:0] v);
    testCtl = 1'b0;
    pi = v;
    #1;
    check("R4", "po before capture", 32'(po), 32'(poOf(model, v)));
    step();
    model = nextOf(model, v);
    padModel = 1'b0;
  endtask

  task automatic t_reset_state();
    rst = 1'b1; testCtl = 1'b1; scanIn = '1; pi = 4'hF;
    step(); step(); step();
    check("R1", "scanOut in reset", 32'(scanOut), 32'h0);
    rst = 1'b0;
    model = '0; padModel = 1'b0;
    shiftPattern(10'h2D3, "R1");
  endtask

  task automatic t_capture_overlap();
    capture(4'h5);
    shiftPattern(10'h1A6, "R7");
    capture(4'hA);
    shiftPattern(10'h3FF, "R3");
    capture(4'h3);
    shiftPattern(10'h000, "R7");
    capture(4'hC);
    shiftPattern(10'h155, "R3");
  endtask

  task automatic t_mapping();
    for (int i = 0; i < POW; i++) begin
      shiftPattern(10'(1) << i, "R5");
      pi = '0;
      #1;
      check("R5", $sformatf("po after single bit %0d", i), 32'(po), 32'(1) << i);
    end
    shiftPattern(10'(1) << (N - 1), "R5");
    shiftPattern(10'h000, "R5");
  endtask

  task automatic t_isolation();
    shiftPattern(10'((1 << L) - 1), "R6");
    shiftPattern(10'h000, "R6");
    shiftPattern(10'h3FF & ~10'((1 << L) - 1), "R6");
    shiftPattern(10'h000, "R6");
  endtask

  task automatic t_latency();
    testCtl = 1'b1;
    for (int t = 0; t < 3 * L; t++) begin
      for (int c = 0; c < NC; c++) begin
        logic exp;
        exp = (t >= L) ? streamBit(t - L, c) : slotBit(model, padModel, c, L - 1 - t);
        check("R2", $sformatf("stream chain%0d step%0d", c, t), 32'(scanOut[c]), 32'(exp));
        scanIn[c] = streamBit(t, c);
      end
      step();
    end
  endtask

  task automatic t_midreset();
    rst = 1'b1; testCtl = 1'b1; scanIn = '1;
    step();
    rst = 1'b0;
    model = '0; padModel = 1'b0;
    shiftPattern(10'h0F0, "R1");
    capture(4'h9);
    shiftPattern(10'h000, "R8");
  endtask

  initial begin
    t_reset_state();
    t_capture_overlap();
    t_mapping();
    t_isolation();
    t_latency();
    t_midreset();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule